// File: doc/BRIEF.md
# Store Queue with Ordering Barriers

This block is a per-core queue that holds retired stores between the execution pipe and the memory port. Each accepted store takes its own slot and leaves through the memory port in program order. A store counts as globally visible once the port accepts it. While stores wait in the queue, a younger cacheable load to the same address takes its data straight from the queue. If several slots match, the most recent store wins.

Three events hold back younger loads until older stores are visible.

- **Fence pulse:** blocks cacheable loads until every store queued at or before the fence cycle has been accepted by the memory port.
- **Locked store:** blocks loads until that store itself has been accepted.
- **Uncacheable load:** is granted only when it is non-speculative and the queue is completely empty. While it waits, the queue takes no new stores, so it empties.

The pipe offers a load on the load port and proceeds only when `ldGo` is high. A load with `ldGo` low is stalled for that cycle.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `memValid` is 0 and `stReady` is 1.
- R2: A store is taken on a cycle with `stValid` and `stReady` both high. Every taken store occupies its own slot and is written to memory separately. Two stores to the same address are never merged.
- R3: Stores leave in the order they were taken, one per cycle in which `memValid` and `memReady` are both high. While `memReady` is low, `memAddr` and `memData` hold the oldest store unchanged.
- R4: With DEPTH stores held, `stReady` is 0 and an offered store is dropped: it never reaches the memory port.
- R5: A granted cacheable load whose address equals a held store raises `ldFwdHit` in the same cycle. `ldFwdData` carries the data of the most recently taken matching store.
- R6: A granted cacheable load that matches no held store gives `ldFwdHit` = 0.
- R7: A `fenceReq` pulse keeps `ldGo` low from the next cycle until all stores taken up to and including the fence cycle have been accepted. A load in the fence cycle itself is older and is not held. Stores taken after the fence do not extend the hold.
- R8: A store taken with `stLock` = 1 keeps `ldGo` low from the next cycle until that store has been accepted by the memory port.
- R9: A load with `ldUncached` = 1 is granted only when `ldSpec` = 0 and the queue is empty. It never forwards. While it is offered, `stReady` is 0.
- R10: A fence raised while the queue is empty causes no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store offered |
| stLock | input | 1 | Offered store belongs to a locked exchange |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| stReady | output | 1 | Queue can take the offered store |
| fenceReq | input | 1 | Single-cycle fence pulse |
| ldValid | input | 1 | Load offered |
| ldUncached | input | 1 | Load targets uncacheable memory |
| ldSpec | input | 1 | Load is still speculative |
| ldAddr | input | AW | Load address |
| ldGo | output | 1 | Load may issue this cycle |
| ldFwdHit | output | 1 | Load data supplied from the queue |
| ldFwdData | output | DW | Forwarded data, zero when no hit |
| memValid | output | 1 | Oldest store presented to memory |
| memAddr | output | AW | Address of oldest store |
| memData | output | DW | Data of oldest store |
| memReady | input | 1 | Memory accepts the store (global visibility) |

## Verification
The bench fills the queue with two stores to one address so that both the youngest-match choice and the no-merge rule are tested. A design that took the oldest match would forward stale data, and one that merged the two stores would issue three memory writes instead of four.

A store is offered against a full queue. A design that overwrote a slot would then drain a foreign address.

The fence test adds a store after the fence and checks that loads resume once the two older stores have left, with the younger store still queued. A design that counted the whole queue would stall too long, and one that ignored the fence would release loads early.

Locked stores, uncacheable loads held off by speculation or by a non-empty queue, and a fence on an empty queue are also run. Each catches a design that releases loads while older stores are still invisible.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;  // write incoming store into tail slot
    logic pop;   // retire head slot after memory accept
  } sbqStrobes_t;
endpackage

// File: rtl/sbq_control.sv
module sbq_control
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic          stLock,
  input  logic          fenceReq,
  input  logic          ldValid,
  input  logic          ldUncached,
  input  logic          ldSpec,
  input  logic          memReady,
  output sbqStrobes_t   strb,
  output logic          stReady,
  output logic          ldGo,
  output logic          memValid,
  output logic [CW-1:0] occupancy
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] occ, occNext;
  logic [CW-1:0] barrier, barrierNext;  // stores still ahead of the newest barrier
  logic          barrierSet;
  logic          uncWait;

  assign uncWait  = ldValid && ldUncached;
  assign stReady  = (occ != FULL) && !uncWait;
  assign memValid = (occ != '0);

  assign strb.push = stValid && stReady;
  assign strb.pop  = memValid && memReady;

  always_comb begin
    occNext = occ;
    if (strb.push && !strb.pop) occNext = occ + CW'(1);
    else if (!strb.push && strb.pop) occNext = occ - CW'(1);
  end

  assign barrierSet = fenceReq || (strb.push && stLock);

  always_comb begin
    barrierNext = barrier;
    if (barrierSet) barrierNext = occNext;
    else if (strb.pop && barrier != '0) barrierNext = barrier - CW'(1);
  end

  always_comb begin
    ldGo = 1'b0;
    if (ldValid && barrier == '0) begin
      if (ldUncached) ldGo = !ldSpec && (occ == '0);
      else            ldGo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ     <= '0;
      barrier <= '0;
    end else begin
      occ     <= occNext;
      barrier <= barrierNext;
    end
  end

  assign occupancy = occ;
endmodule

// File: rtl/sbq_datapath.sv
module sbq_datapath
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  sbqStrobes_t   strb,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [AW-1:0] ldAddr,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          fwdHit,
  output logic [DW-1:0] fwdData
);
  logic [AW-1:0]    slotAddr [DEPTH];
  logic [DW-1:0]    slotData [DEPTH];
  logic [DEPTH-1:0] slotLive;
  logic [PW-1:0]    headPtr, tailPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      slotLive <= '0;
    end else begin
      if (strb.push) begin
        slotLive[tailPtr] <= 1'b1;
        tailPtr           <= tailPtr + PW'(1);
      end
      if (strb.pop) begin
        slotLive[headPtr] <= 1'b0;
        headPtr           <= headPtr + PW'(1);
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.push && tailPtr == PW'(g)) begin
          slotAddr[g] <= stAddr;
          slotData[g] <= stData;
        end
      end
    end
  endgenerate

  assign memAddr = slotAddr[headPtr];
  assign memData = slotData[headPtr];

  // walk from oldest to youngest; the last match seen is the youngest
  logic [PW-1:0] scanIdx;
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    scanIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = headPtr + PW'(k);
      if (slotLive[scanIdx] && slotAddr[scanIdx] == ldAddr) begin
        fwdHit  = 1'b1;
        fwdData = slotData[scanIdx];
      end
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic          stLock,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  output logic          stReady,
  input  logic          fenceReq,
  input  logic          ldValid,
  input  logic          ldUncached,
  input  logic          ldSpec,
  input  logic [AW-1:0] ldAddr,
  output logic          ldGo,
  output logic          ldFwdHit,
  output logic [DW-1:0] ldFwdData,
  output logic          memValid,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  input  logic          memReady
);
  localparam int CW = $clog2(DEPTH + 1);

  sbqStrobes_t   strb;
  logic [CW-1:0] occupancy;
  logic          fwdHit;
  logic [DW-1:0] fwdData;

  sbq_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stLock(stLock),
    .fenceReq(fenceReq), .ldValid(ldValid), .ldUncached(ldUncached),
    .ldSpec(ldSpec), .memReady(memReady), .strb(strb), .stReady(stReady),
    .ldGo(ldGo), .memValid(memValid), .occupancy(occupancy)
  );

  sbq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stAddr(stAddr), .stData(stData),
    .ldAddr(ldAddr), .memAddr(memAddr), .memData(memData),
    .fwdHit(fwdHit), .fwdData(fwdData)
  );

  assign ldFwdHit  = ldGo && !ldUncached && fwdHit;
  assign ldFwdData = ldFwdHit ? fwdData : '0;
endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          stValid,
  input logic          stLock,
  input logic          stReady,
  input logic          fenceReq,
  input logic          ldValid,
  input logic          ldUncached,
  input logic          ldSpec,
  input logic          ldGo,
  input logic          ldFwdHit,
  input logic          memValid,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memData,
  input logic          memReady,
  input logic [CW-1:0] occupancy
);
  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == '0 |-> !memValid);

  a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == CW'(DEPTH) |-> !stReady);

  a_r3_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  a_r5_fwd_granted: assert property (@(posedge clk) disable iff (!rstN)
    ldFwdHit |-> ldGo && !ldUncached);

  a_r7_fence_holds: assert property (@(posedge clk) disable iff (!rstN)
    fenceReq && occupancy != '0 && !(memValid && memReady) |=> !ldGo);

  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    stValid && stReady && stLock |=> !ldGo);

  a_r9_unc_safe: assert property (@(posedge clk) disable iff (!rstN)
    ldGo && ldUncached |-> !ldSpec && occupancy == '0 && !ldFwdHit);

  a_r9_unc_no_store: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && ldUncached |-> !stReady);
endmodule

bind store_queue store_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stLock(stLock),
  .stReady(stReady), .fenceReq(fenceReq), .ldValid(ldValid),
  .ldUncached(ldUncached), .ldSpec(ldSpec), .ldGo(ldGo),
  .ldFwdHit(ldFwdHit), .memValid(memValid), .memAddr(memAddr),
  .memData(memData), .memReady(memReady), .occupancy(occupancy)
);

// File: tb/store_queue_tb_top.sv
module store_queue_tb_top;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 0, stLock = 0, fenceReq = 0;
  logic ldValid = 0, ldUncached = 0, ldSpec = 0, memReady = 0;
  logic [AW-1:0] stAddr = '0, ldAddr = '0;
  logic [DW-1:0] stData = '0;
  logic stReady, ldGo, ldFwdHit, memValid;
  logic [DW-1:0] ldFwdData, memData;
  logic [AW-1:0] memAddr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stLock(stLock),
    .stAddr(stAddr), .stData(stData), .stReady(stReady),
    .fenceReq(fenceReq), .ldValid(ldValid), .ldUncached(ldUncached),
    .ldSpec(ldSpec), .ldAddr(ldAddr), .ldGo(ldGo), .ldFwdHit(ldFwdHit),
    .ldFwdData(ldFwdData), .memValid(memValid), .memAddr(memAddr),
    .memData(memData), .memReady(memReady)
  );

  // load address, expected hit, expected forwarded data
  localparam logic [AW+DW:0] FWD_TAB [5] = '{
    {16'h0010, 1'b1, 32'h1111_0002},
    {16'h0020, 1'b1, 32'h2222_0001},
    {16'h0030, 1'b1, 32'h3333_0001},
    {16'h0040, 1'b0, 32'h0000_0000},
    {16'h0050, 1'b0, 32'h0000_0000}
  };

  localparam logic [AW+DW-1:0] DRAIN_EXP [4] = '{
    {16'h0010, 32'h1111_0001},
    {16'h0020, 32'h2222_0001},
    {16'h0010, 32'h1111_0002},
    {16'h0030, 32'h3333_0001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic pushStore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic lk);
    stValid = 1; stAddr = a; stData = d; stLock = lk;
    tick();
    stValid = 0; stLock = 0;
  endtask

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #2;
    chk("R1 memValid", 64'(memValid), 64'd0);
    chk("R1 stReady", 64'(stReady), 64'd1);

    // fill queue, memory stalled
    pushStore(16'h0010, 32'h1111_0001, 0);
    pushStore(16'h0020, 32'h2222_0001, 0);
    pushStore(16'h0010, 32'h1111_0002, 0);
    pushStore(16'h0030, 32'h3333_0001, 0);
    #2 chk("R4 full stReady", 64'(stReady), 64'd0);
    chk("R3 head addr held", 64'(memAddr), 64'h0010);
    // offered store against full queue must be dropped
    pushStore(16'h0040, 32'hDEAD_BEEF, 0);

    // forwarding table
    for (int i = 0; i < 5; i++) begin
      ldValid = 1; ldAddr = FWD_TAB[i][AW+DW:DW+1];
      #2;
      chk("R5/R6 ldGo", 64'(ldGo), 64'd1);
      chk("R5/R6 hit", 64'(ldFwdHit), 64'(FWD_TAB[i][DW]));
      chk("R5 data", 64'(ldFwdData), 64'(FWD_TAB[i][DW-1:0]));
      tick();
    end
    ldValid = 0;

    // drain in order, no merging
    #2 chk("R3 head data held", 64'(memData), 64'h1111_0001);
    memReady = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R2/R3 valid", 64'(memValid), 64'd1);
      chk("R2/R3 drain", 64'({memAddr, memData}), 64'(DRAIN_EXP[k]));
      tick();
    end
    chk("R4 dropped store absent", 64'(memValid), 64'd0);
    memReady = 0;

    // fence: two older stores, one younger
    pushStore(16'h0100, 32'hD1, 0);
    pushStore(16'h0104, 32'hD2, 0);
    fenceReq = 1; ldValid = 1; ldAddr = 16'h0200;
    #2 chk("R7 same-cycle load free", 64'(ldGo), 64'd1);
    tick();
    fenceReq = 0;
    ldValid = 0;
    pushStore(16'h0108, 32'hD3, 0);
    ldValid = 1;
    #2 chk("R7 held", 64'(ldGo), 64'd0);
    memReady = 1;
    tick();
    chk("R7 held after one drain", 64'(ldGo), 64'd0);
    tick();
    chk("R7 released", 64'(ldGo), 64'd1);
    chk("R7 younger still queued", 64'(memAddr), 64'h0108);
    tick();
    memReady = 0;
    ldValid = 0;
    chk("R7 drained", 64'(memValid), 64'd0);

    // locked store
    pushStore(16'h0300, 32'hE1, 0);
    pushStore(16'h0304, 32'hE2, 1);
    ldValid = 1; ldAddr = 16'h0300;
    #2 chk("R8 held", 64'(ldGo), 64'd0);
    chk("R8 no fwd while held", 64'(ldFwdHit), 64'd0);
    memReady = 1;
    tick();
    chk("R8 held until lock store visible", 64'(ldGo), 64'd0);
    tick();
    chk("R8 released", 64'(ldGo), 64'd1);
    memReady = 0;
    ldValid = 0;

    // fence with empty queue
    fenceReq = 1;
    tick();
    fenceReq = 0;
    ldValid = 1; ldAddr = 16'h0777;
    #2 chk("R10 no hold", 64'(ldGo), 64'd1);
    tick();
    ldValid = 0;

    // uncacheable load
    pushStore(16'h0400, 32'hF1, 0);
    ldValid = 1; ldUncached = 1; ldSpec = 0; ldAddr = 16'h0400;
    stValid = 1; stAddr = 16'h0500; stData = 32'hF2;
    #2 chk("R9 waits for empty", 64'(ldGo), 64'd0);
    chk("R9 store blocked", 64'(stReady), 64'd0);
    memReady = 1;
    tick();
    #1 chk("R9 granted", 64'(ldGo), 64'd1);
    chk("R9 no forward", 64'(ldFwdHit), 64'd0);
    chk("R9 queue empty", 64'(memValid), 64'd0);
    tick();
    stValid = 0;
    ldSpec = 1;
    #1 chk("R9 speculative held", 64'(ldGo), 64'd0);
    chk("R9 blocked store absent", 64'(memValid), 64'd0);
    ldValid = 0; ldUncached = 0; ldSpec = 0; memReady = 0;
    tick();

    finishRun();
  end
endmodule